// File: doc/BRIEF.md
# Terminal Transmit Register Interface

This block is the register-side front end of a character terminal's transmit path. A processor reaches it over a simple register bus with two word locations: a status word and a transmit buffer. Writing the buffer hands a character to a downstream transmitter by pulsing a start strobe, with the character held on an 8-bit data output. The downstream side answers with a one-cycle completion pulse. The block then sets its done flag and, if interrupts are enabled, raises an interrupt request.

A width-mode input chooses whether the character sent downstream keeps all 8 bits or is cut to 7 bits. The stored buffer value is never altered by the mode. After reset the done flag is already set, so software may send its first character without waiting. A buffer write arriving while a character is still outstanding abandons that character and starts over with the new one. Serialisation, line timing and interrupt vectoring belong to other blocks.

Top module: `term_tx_port`

## Requirements
- R1: `bus_addr[1]` picks the location: 0 is the status word, 1 is the transmit buffer. `bus_rdata` is combinational. The status word reads as bit 7 = done, bit 6 = interrupt enable, all other bits 0. The buffer reads as the stored character in bits 7:0 with bits 15:8 zero.
- R2: A synchronous reset clears the buffer to 0, sets done, clears enable, drops `irq` and cancels any outstanding transmission, so a later completion pulse has no effect.
- R3: A status write with `bus_addr[0]`=0 loads enable from `bus_wdata[6]`. Every other bit written, including bit 7, is ignored. A status write with `bus_addr[0]`=1 changes nothing.
- R4: A status write that clears enable drops `irq` on the next edge. A status write that sets enable while done=1 and enable was 0 raises `irq`. Setting enable while done=0 leaves `irq` low.
- R5: A buffer write with `bus_addr[0]`=0 stores `bus_wdata[7:0]`. A buffer write with `bus_addr[0]`=1 stores nothing. Both kinds clear done and `irq`, and `tx_start` is high for exactly the one cycle that follows the write edge.
- R6: A `tx_complete` pulse while a transmission is outstanding sets done on the next edge, and also sets `irq` if enable is 1.
- R7: A `tx_complete` pulse with no transmission outstanding is ignored.
- R8: `tx_char` is the stored character with bit 7 forced to 0 when `mode_8bit`=0, and the full stored character when `mode_8bit`=1.
- R9: Reading the buffer or the status word changes no state.
- R10: A buffer write while a transmission is outstanding restarts it. A fresh `tx_start` pulse is issued with the new character, and a single completion then finishes the restarted transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Bit 1 selects the location, bit 0 selects the high byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data |
| mode_8bit | input | 1 | 1 = 8-bit characters, 0 = 7-bit |
| tx_start | output | 1 | One-cycle strobe that starts a transmission |
| tx_char | output | 8 | Masked character for the transmitter |
| tx_complete | input | 1 | Completion pulse from the transmitter |
| irq | output | 1 | Interrupt request |

## Verification
Every register result of a write or a completion pulse is due one edge after the access. This covers done, enable, `irq`, the stored character and the start strobe. Read data and `tx_char` are combinational and are due in the same cycle. The bench drives each access on a falling edge and holds it across one rising edge. It samples the registered results at the next falling edge, and it checks that `tx_start` has dropped again one cycle after that. Read data and the masked character are sampled a short delay after the address or mode input settles, before any clock edge.

// File: rtl/term_tx_pkg.sv
package term_tx_pkg;

    parameter int BUS_W  = 16;
    parameter int CHAR_W = 8;

    // bit positions in the status word that software decodes
    localparam int DONE_BIT = 7;
    localparam int IE_BIT   = 6;

    typedef enum logic {
        LOC_STATUS = 1'b0,
        LOC_BUFFER = 1'b1
    } loc_e;

    typedef struct packed {
        logic status_wr;   // even-byte status write
        logic buffer_wr;   // buffer write, either byte
        logic low_byte;    // even address
    } access_t;

    function automatic access_t decode_access(input logic sel, input logic wr,
                                              input logic [1:0] addr);
        access_t a;
        a.low_byte  = ~addr[0];
        a.status_wr = sel && wr && (loc_e'(addr[1]) == LOC_STATUS) && ~addr[0];
        a.buffer_wr = sel && wr && (loc_e'(addr[1]) == LOC_BUFFER);
        return a;
    endfunction

    function automatic logic [CHAR_W-1:0] mask_char(input logic [CHAR_W-1:0] c,
                                                    input logic eight);
        return eight ? c : {1'b0, c[CHAR_W-2:0]};
    endfunction

endpackage

// File: rtl/tx_status_reg.sv
module tx_status_reg (
    input  logic clk,
    input  logic rst,
    input  logic ie_wr,
    input  logic ie_val,
    input  logic buf_wr,
    input  logic complete_ok,
    output logic done,
    output logic ie,
    output logic irq
);

    logic ie_next;
    assign ie_next = ie_wr ? ie_val : ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b1;
            ie   <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (buf_wr) begin
                done <= 1'b0;
                irq  <= 1'b0;
            end else if (complete_ok) begin
                done <= 1'b1;
                if (ie_next) irq <= 1'b1;
            end
            if (ie_wr) begin
                ie <= ie_val;
                if (!ie_val)
                    irq <= 1'b0;
                else if (done && !ie)
                    irq <= 1'b1;
            end
        end
    end

    // R6: a request is only ever held with both enable and done set
    a_r6_irq_needs_done_ie: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ie && done));

    // R5: a buffer write withdraws done and the request
    a_r5_write_clears_done: assert property (@(posedge clk) disable iff (rst)
        buf_wr |=> (!done && !irq));

    // R4: disabling drops the request
    a_r4_disable_drops_irq: assert property (@(posedge clk) disable iff (rst)
        (ie_wr && !ie_val) |=> !irq);

    // R6: an accepted completion sets done
    a_r6_complete_sets_done: assert property (@(posedge clk) disable iff (rst)
        (complete_ok && !buf_wr) |=> done);

endmodule

// File: rtl/tx_data_buffer.sv
module tx_data_buffer
    import term_tx_pkg::*;
#(
    parameter int BW = BUS_W,
    parameter int CW = CHAR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          buf_wr,
    input  logic          low_byte,
    input  logic [BW-1:0] wdata,
    input  logic          complete_in,
    input  logic          mode_8bit,
    output logic [CW-1:0] buf_q,
    output logic          tx_start,
    output logic [CW-1:0] tx_char,
    output logic          complete_ok
);

    logic pending;

    // a restart in the same cycle takes precedence over a completion
    assign complete_ok = complete_in && pending && !buf_wr;
    assign tx_char     = mask_char(buf_q, mode_8bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q    <= '0;
            tx_start <= 1'b0;
            pending  <= 1'b0;
        end else begin
            tx_start <= buf_wr;
            if (buf_wr) begin
                pending <= 1'b1;
                if (low_byte) buf_q <= wdata[CW-1:0];
            end else if (complete_ok) begin
                pending <= 1'b0;
            end
        end
    end

    // R5/R10: every buffer write produces a start strobe
    a_r5_start_follows_write: assert property (@(posedge clk) disable iff (rst)
        buf_wr |=> tx_start);

    // R7: no strobe without a write
    a_r7_no_start_without_write: assert property (@(posedge clk) disable iff (rst)
        !buf_wr |=> !tx_start);

    // R7: a stray completion leaves the transmission state alone
    a_r7_stray_complete_ignored: assert property (@(posedge clk) disable iff (rst)
        (complete_in && !pending && !buf_wr) |=> !pending);

    // R8: seven-bit mode never sends the top bit
    a_r8_seven_bit_mask: assert property (@(posedge clk) disable iff (rst)
        !mode_8bit |-> !tx_char[CW-1]);

endmodule

// File: rtl/term_tx_port.sv
module term_tx_port
    import term_tx_pkg::*;
#(
    parameter int BW = BUS_W,
    parameter int CW = CHAR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [BW-1:0] bus_wdata,
    output logic [BW-1:0] bus_rdata,
    input  logic          mode_8bit,
    output logic          tx_start,
    output logic [CW-1:0] tx_char,
    input  logic          tx_complete,
    output logic          irq
);

    access_t       acc;
    logic          done, ie, complete_ok;
    logic [CW-1:0] buf_q;

    assign acc = decode_access(bus_sel, bus_wr, bus_addr);

    tx_status_reg u_status (
        .clk         (clk),
        .rst         (rst),
        .ie_wr       (acc.status_wr),
        .ie_val      (bus_wdata[IE_BIT]),
        .buf_wr      (acc.buffer_wr),
        .complete_ok (complete_ok),
        .done        (done),
        .ie          (ie),
        .irq         (irq)
    );

    tx_data_buffer #(.BW(BW), .CW(CW)) u_buffer (
        .clk         (clk),
        .rst         (rst),
        .buf_wr      (acc.buffer_wr),
        .low_byte    (acc.low_byte),
        .wdata       (bus_wdata),
        .complete_in (tx_complete),
        .mode_8bit   (mode_8bit),
        .buf_q       (buf_q),
        .tx_start    (tx_start),
        .tx_char     (tx_char),
        .complete_ok (complete_ok)
    );

    // R1: read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (loc_e'(bus_addr[1]) == LOC_STATUS) begin
            bus_rdata[DONE_BIT] = done;
            bus_rdata[IE_BIT]   = ie;
        end else begin
            bus_rdata[CW-1:0] = buf_q;
        end
    end

    // R2: state straight after reset
    a_r2_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (done && !ie && !irq && !tx_start && (buf_q == '0)));

    // R9: a read leaves done and enable untouched
    a_r9_read_no_effect: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && !tx_complete) |=> ($stable(done) && $stable(ie)));

endmodule

// File: tb/term_tx_port_bench.sv
module term_tx_port_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_wr, mode_8bit, tx_complete;
    logic [1:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        tx_start, irq;
    logic [7:0]  tx_char;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    term_tx_port u_term_tx_port (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mode_8bit(mode_8bit), .tx_start(tx_start), .tx_char(tx_char),
        .tx_complete(tx_complete), .irq(irq)
    );

    localparam logic [1:0] A_STAT = 2'b00, A_STAT_HI = 2'b01,
                           A_BUF = 2'b10, A_BUF_HI = 2'b11;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic complete_pulse();
        tx_complete = 1;
        @(posedge clk); @(negedge clk);
        tx_complete = 0;
    endtask

    task automatic idle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1; idle(); idle(); rst = 0;
    endtask

    task automatic t_reset_state();
        logic [15:0] d;
        do_reset();
        check("R2 irq", {15'b0, irq}, 16'h0);
        check("R2 start", {15'b0, tx_start}, 16'h0);
        bus_read(A_STAT, d); check("R2/R1 status", d, 16'h0080);
        bus_read(A_BUF, d);  check("R2/R1 buffer", d, 16'h0000);
    endtask

    task automatic t_status_writes();
        logic [15:0] d;
        bus_write(A_STAT_HI, 16'hFFFF);
        bus_read(A_STAT, d); check("R3 odd status write ignored", d, 16'h0080);
        check("R3 odd no irq", {15'b0, irq}, 16'h0);
        bus_write(A_STAT, 16'h0040);
        check("R4 enable with done raises irq", {15'b0, irq}, 16'h1);
        bus_read(A_STAT, d); check("R3 bit7 write ignored", d, 16'h00C0);
        bus_write(A_STAT, 16'h0000);
        check("R4 disable drops irq", {15'b0, irq}, 16'h0);
        bus_read(A_STAT, d); check("R3 enable cleared", d, 16'h0080);
    endtask

    task automatic t_even_write_complete();
        logic [15:0] d;
        mode_8bit = 1;
        bus_write(A_BUF, 16'hAB3C);
        check("R5 start pulse", {15'b0, tx_start}, 16'h1);
        check("R5 char", {8'h0, tx_char}, 16'h003C);
        idle();
        check("R5 start one cycle", {15'b0, tx_start}, 16'h0);
        bus_read(A_STAT, d); check("R5 done cleared", d, 16'h0000);
        bus_write(A_STAT, 16'h0040);
        check("R4 enable while busy no irq", {15'b0, irq}, 16'h0);
        complete_pulse();
        check("R6 irq on completion", {15'b0, irq}, 16'h1);
        bus_read(A_STAT, d); check("R6 done set", d, 16'h00C0);
        bus_read(A_BUF, d);  check("R5 low byte stored", d, 16'h003C);
    endtask

    task automatic t_mask_and_odd();
        logic [15:0] d;
        mode_8bit = 1;
        bus_write(A_BUF, 16'h00C5);
        check("R5 write clears irq", {15'b0, irq}, 16'h0);
        check("R8 8-bit char", {8'h0, tx_char}, 16'h00C5);
        mode_8bit = 0; #1;
        check("R8 7-bit char", {8'h0, tx_char}, 16'h0045);
        bus_read(A_BUF, d); check("R8 buffer unmasked", d, 16'h00C5);
        complete_pulse();
        bus_write(A_BUF_HI, 16'h5A00);
        check("R5 odd write starts", {15'b0, tx_start}, 16'h1);
        bus_read(A_BUF, d); check("R5 odd write stores nothing", d, 16'h00C5);
        bus_read(A_STAT, d); check("R5 odd write clears done", d, 16'h0040);
        complete_pulse();
        check("R6 irq after odd write", {15'b0, irq}, 16'h1);
        mode_8bit = 1;
    endtask

    task automatic t_spurious_and_reads();
        logic [15:0] d;
        bus_write(A_STAT, 16'h0000);
        complete_pulse();
        check("R7 stray pulse no irq", {15'b0, irq}, 16'h0);
        check("R7 stray pulse no start", {15'b0, tx_start}, 16'h0);
        bus_read(A_STAT, d); check("R7 status unchanged", d, 16'h0080);
        bus_write(A_BUF, 16'h0011);
        bus_read(A_BUF, d); bus_read(A_BUF, d);
        bus_read(A_STAT, d); check("R9 reads keep done clear", d, 16'h0000);
        check("R9 buffer kept", {8'h0, tx_char}, 16'h0011);
        complete_pulse();
        bus_read(A_STAT, d); check("R9 done after completion", d, 16'h0080);
    endtask

    task automatic t_restart();
        logic [15:0] d;
        bus_write(A_STAT, 16'h0040);
        bus_write(A_BUF, 16'h0021);
        idle();
        bus_write(A_BUF, 16'h0022);
        check("R10 restart start pulse", {15'b0, tx_start}, 16'h1);
        check("R10 new char", {8'h0, tx_char}, 16'h0022);
        bus_read(A_STAT, d); check("R10 still busy", d, 16'h0040);
        complete_pulse();
        check("R10 single completion finishes", {15'b0, irq}, 16'h1);
        bus_read(A_STAT, d); check("R10 done", d, 16'h00C0);
    endtask

    task automatic t_reset_cancels();
        logic [15:0] d;
        bus_write(A_BUF, 16'h0033);
        do_reset();
        bus_write(A_STAT, 16'h0000);
        bus_read(A_STAT, d); check("R2 done after reset", d, 16'h0080);
        bus_read(A_BUF, d);  check("R2 buffer cleared", d, 16'h0000);
        bus_write(A_STAT, 16'h0040);
        bus_write(A_STAT, 16'h0000);
        bus_write(A_BUF, 16'h0044);
        do_reset();
        complete_pulse();
        bus_read(A_STAT, d); check("R2 cancelled transmission", d, 16'h0080);
        check("R2 no irq after cancel", {15'b0, irq}, 16'h0);
    endtask

    initial begin
        rst = 1; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        mode_8bit = 1; tx_complete = 0;
        @(negedge clk);
        t_reset_state();
        t_status_writes();
        t_even_write_complete();
        t_mask_and_odd();
        t_spurious_and_reads();
        t_restart();
        t_reset_cancels();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule